// File: doc/BRIEF.md
# Interrupt Coalescing and Credit Controller

This block manages one interrupt vector. A one-cycle `assert_ev` input marks an interrupt-worthy event, and the block answers with a one-cycle `irq_send` pulse. A send is allowed only while the vector is unmasked and a coalescing countdown has run out. An event that cannot be sent at once is held as pending and goes out as soon as both conditions allow. Each send reloads the countdown from a programmable initial value. The countdown then moves down by one on every cycle where `tick_en` is high, and `tick_en` comes from an external microsecond prescaler. An optional auto-mask setting masks the vector again after every send.

A signed 16-bit credit counter adds one for each send. Software retires credits by writing a decrement to the credit word. If that write brings the counter to exactly zero, any pending event that has not been sent is discarded. The upper half of the same credit word carries two action bits. One unmasks the vector and the other restarts the countdown, so a single write can both retire credits and rearm the vector.

Registers are reached through a flat port with an address, write data, a write strobe and combinational read data. Every register write takes effect at the next clock edge.

Top module: `intr_coal_ctrl`

## Requirements
- R1: A send reloads the coalescing counter (offset 0x10) with the initial value held at that edge. While the counter is nonzero, no send happens.
- R2: With an initial value of 0, an event on each of several consecutive cycles produces a send on each following cycle while unmasked.
- R3: The mask (offset 0x04, bit 0) resets to 1 and blocks sends. An event that arrives while masked is held, and it is sent in the cycle after the edge that clears the mask.
- R4: If an event is pending when the counter reaches 0, it is sent at the next edge without a new event.
- R5: The credit word (offset 0x08, bits 15:0, two's complement) adds 1 per send. A write subtracts `wdata[15:0]`, wrapping to negative values, and the counter resets to 0.
- R6: A credit write whose result is exactly 0 clears the pending event, so no send follows once the counter expires.
- R7: In a credit write, `wdata[16]`=1 clears the mask and `wdata[17]`=1 reloads the counter from the initial value. Neither bit is stored.
- R8: Auto-mask (offset 0x0C, bit 0, reset 0) set to 1 sets the mask in the same edge as each send.
- R9: The initial value (offset 0x00) saturates at 0x3F when a larger value is written.
- R10: The counter at 0x10 can only be read, and writes to it are ignored. Reads of unused offsets return 0.
- R11: The counter decrements only in cycles with `tick_en`=1 and holds its value otherwise.
- R12: A credit write in the same cycle as a send leaves the counter at old + 1 − written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tick_en | input | 1 | Counter decrement enable |
| assert_ev | input | 1 | One-cycle interrupt event |
| irq_send | output | 1 | One-cycle interrupt send, one cycle after the deciding edge |

## Verification
The hardest state to reach is a pending event that is dropped by credit retirement. It needs a running countdown to hold back an event, a credit write that lands on exactly zero before the countdown expires, and then an expiry that produces no send. The stimulus sets the initial value to 3 and uses the credit count left over from earlier sends to pick the exact decrement. It then ticks the counter down and watches `irq_send` stay low. It also forces a send and a credit write into the same cycle to check their combined effect on the counter.

// File: rtl/intr_coal_pkg.sv
package intr_coal_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_COAL_INIT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK      = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CREDIT    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_AUTO_MASK = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_COAL_CUR  = 8'h10;

    localparam int unsigned BIT_UNMASK = 16;
    localparam int unsigned BIT_RELOAD = 17;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COAL_INIT,
        SEL_MASK,
        SEL_CREDIT,
        SEL_AUTO_MASK,
        SEL_COAL_CUR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_COAL_INIT: s = SEL_COAL_INIT;
            OFS_MASK:      s = SEL_MASK;
            OFS_CREDIT:    s = SEL_CREDIT;
            OFS_AUTO_MASK: s = SEL_AUTO_MASK;
            OFS_COAL_CUR:  s = SEL_COAL_CUR;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/coal_timer.sv
module coal_timer #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec_en,
    input  logic [W-1:0] dec_val,
    output logic [W-1:0] cnt,
    output logic         hit_zero
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] sub_val;

    always_comb begin
        sub_val  = dec_en ? dec_val : '0;
        cnt_d    = cnt_q + W'(inc) - sub_val;
        hit_zero = dec_en && (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/reg_rdmux.sv
module reg_rdmux
    import intr_coal_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned COAL_W = 6,
    parameter int unsigned CRED_W = 16
) (
    input  reg_sel_e          sel,
    input  logic [COAL_W-1:0] coal_init,
    input  logic              mask,
    input  logic [CRED_W-1:0] credit,
    input  logic              auto_mask,
    input  logic [COAL_W-1:0] coal_cur,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_COAL_INIT: rdata = DATA_W'(coal_init);
            SEL_MASK:      rdata = DATA_W'(mask);
            SEL_CREDIT:    rdata = DATA_W'(credit);
            SEL_AUTO_MASK: rdata = DATA_W'(auto_mask);
            SEL_COAL_CUR:  rdata = DATA_W'(coal_cur);
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_coal_ctrl.sv
module intr_coal_ctrl
    import intr_coal_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CRED_W   = 16,
    parameter int unsigned COAL_MAX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_en,
    input  logic              assert_ev,
    output logic              irq_send
);

    localparam int unsigned COAL_W = $clog2(COAL_MAX + 1);

    typedef struct packed {
        logic [COAL_W-1:0] coal_init;
        logic              mask;
        logic              auto_mask;
        logic              pending;
        logic              send;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_sel_e          sel;
    logic              wr_init, wr_mask, wr_auto, cred_wr;
    logic              send_fire, timer_load, drop;
    logic              timer_zero;
    logic [COAL_W-1:0] coal_cur;
    logic [CRED_W-1:0] cred_q;

    logic              mask_q, pending_q, auto_q;
    logic [COAL_W-1:0] coal_init_q;

    always_comb begin
        sel     = decode_addr(reg_addr);
        wr_init = reg_wr && (sel == SEL_COAL_INIT);
        wr_mask = reg_wr && (sel == SEL_MASK);
        wr_auto = reg_wr && (sel == SEL_AUTO_MASK);
        cred_wr = reg_wr && (sel == SEL_CREDIT);

        send_fire  = !ctl_q.mask && timer_zero && (ctl_q.pending || assert_ev);
        timer_load = send_fire || (cred_wr && reg_wdata[BIT_RELOAD]);

        ctl_d      = ctl_q;
        ctl_d.send = send_fire;

        if (wr_init) begin
            if (reg_wdata > DATA_W'(COAL_MAX)) begin
                ctl_d.coal_init = COAL_W'(COAL_MAX);
            end else begin
                ctl_d.coal_init = reg_wdata[COAL_W-1:0];
            end
        end

        if (wr_mask) begin
            ctl_d.mask = reg_wdata[0];
        end
        if (cred_wr && reg_wdata[BIT_UNMASK]) begin
            ctl_d.mask = 1'b0;
        end
        if (send_fire && ctl_q.auto_mask) begin
            ctl_d.mask = 1'b1;
        end

        if (wr_auto) begin
            ctl_d.auto_mask = reg_wdata[0];
        end

        if (send_fire) begin
            ctl_d.pending = 1'b0;
        end else if (assert_ev) begin
            ctl_d.pending = 1'b1;
        end
        if (drop) begin
            ctl_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{coal_init: '0, mask: 1'b1, auto_mask: 1'b0,
                       pending: 1'b0, send: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    coal_timer #(.W(COAL_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (ctl_q.coal_init),
        .tick     (tick_en),
        .cnt      (coal_cur),
        .expired  (timer_zero)
    );

    credit_ctr #(.W(CRED_W)) credit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (send_fire),
        .dec_en   (cred_wr),
        .dec_val  (reg_wdata[CRED_W-1:0]),
        .cnt      (cred_q),
        .hit_zero (drop)
    );

    reg_rdmux #(.DATA_W(DATA_W), .COAL_W(COAL_W), .CRED_W(CRED_W)) rdmux_i (
        .sel       (sel),
        .coal_init (ctl_q.coal_init),
        .mask      (ctl_q.mask),
        .credit    (cred_q),
        .auto_mask (ctl_q.auto_mask),
        .coal_cur  (coal_cur),
        .rdata     (reg_rdata)
    );

    assign mask_q      = ctl_q.mask;
    assign pending_q   = ctl_q.pending;
    assign auto_q      = ctl_q.auto_mask;
    assign coal_init_q = ctl_q.coal_init;
    assign irq_send    = ctl_q.send;

endmodule

// File: rtl/intr_coal_ctrl_chk.sv
module intr_coal_ctrl_chk #(
    parameter int unsigned COAL_W = 6,
    parameter int unsigned CRED_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_send,
    input logic              tick_en,
    input logic              cred_wr,
    input logic [CRED_W-1:0] cred_val,
    input logic [CRED_W-1:0] cred_q,
    input logic              mask_q,
    input logic              pending_q,
    input logic              auto_q,
    input logic [COAL_W-1:0] coal_cur,
    input logic [COAL_W-1:0] coal_init_q
);

    AST_SEND_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_send |-> ($past(coal_cur) == '0)); // R1

    AST_SEND_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_send |-> (coal_cur == $past(coal_init_q))); // R1

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_send |-> !$past(mask_q)); // R3

    AST_PENDING_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q && pending_q && (coal_cur == '0)) |=> irq_send); // R4

    AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_send && !$past(cred_wr)) |-> (cred_q == $past(cred_q) + CRED_W'(1))); // R5

    AST_DROP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cred_wr) && (cred_q == '0) && !irq_send) |-> !pending_q); // R6

    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_send && $past(auto_q)) |-> mask_q); // R8

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_en) && !irq_send && !$past(cred_wr)) |-> (coal_cur == $past(coal_cur))); // R11

    AST_NET_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_send && $past(cred_wr)) |->
        (cred_q == $past(cred_q) + CRED_W'(1) - $past(cred_val))); // R12

endmodule

bind intr_coal_ctrl intr_coal_ctrl_chk #(.COAL_W(COAL_W), .CRED_W(CRED_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_send    (irq_send),
    .tick_en     (tick_en),
    .cred_wr     (cred_wr),
    .cred_val    (reg_wdata[CRED_W-1:0]),
    .cred_q      (cred_q),
    .mask_q      (mask_q),
    .pending_q   (pending_q),
    .auto_q      (auto_q),
    .coal_cur    (coal_cur),
    .coal_init_q (coal_init_q)
);

// File: tb/intr_coal_ctrl_tb_top.sv
`timescale 1ns/1ps
module intr_coal_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        tick_en = 1'b0;
    logic        assert_ev = 1'b0;
    logic        irq_send;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intr_coal_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en),
        .assert_ev (assert_ev),
        .irq_send  (irq_send)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        ev;
        logic        tk;
        logic        exp_irq;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h04, 32'h0,   1'b0, 1'b0, 1'b0, 32'h1},  // R3 mask resets to 1
        '{1'b1, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0},  // R10 init reset 0
        '{1'b1, 1'b0, 8'h08, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0},  // R5 credits reset 0
        '{1'b1, 1'b0, 8'h0C, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0},  // R8 auto-mask reset 0
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b1, 1'b0, 1'b0, 32'h0},  // R3 masked event held
        '{1'b0, 1'b1, 8'h04, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0},  // R3 unmask write
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b1, 32'h0},  // R3 held event sent
        '{1'b1, 1'b0, 8'h08, 32'h0,   1'b0, 1'b0, 1'b0, 32'h1},  // R5 one credit
        '{1'b0, 1'b1, 8'h00, 32'h1FF, 1'b0, 1'b0, 1'b0, 32'h0},  // R9 oversize write
        '{1'b1, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3F}, // R9 saturated
        '{1'b0, 1'b1, 8'h00, 32'h3,   1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3},  // R10 init readback
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b1, 1'b0, 1'b1, 32'h0},  // R1 send at count 0
        '{1'b1, 1'b0, 8'h10, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3},  // R1 reload on send
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b1, 1'b0, 1'b0, 32'h0},  // R1 blocked while counting
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0},  // R11 no tick
        '{1'b1, 1'b0, 8'h10, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3},  // R11 held
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b1, 1'b0, 32'h0},  // R11 tick
        '{1'b1, 1'b0, 8'h10, 32'h0,   1'b0, 1'b0, 1'b0, 32'h2},  // R11 decremented
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b1, 1'b0, 32'h0},
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b1, 1'b0, 32'h0},
        '{1'b0, 1'b0, 8'h00, 32'h0,   1'b0, 1'b0, 1'b1, 32'h0},  // R4 pending sent on expiry
        '{1'b1, 1'b0, 8'h08, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3},  // R5 three credits
        '{1'b0, 1'b1, 8'h08, 32'h1,   1'b0, 1'b0, 1'b0, 32'h0},  // R5 retire one
        '{1'b1, 1'b0, 8'h08, 32'h0,   1'b0, 1'b0, 1'b0, 32'h2},  // R5 two left
        '{1'b0, 1'b1, 8'h10, 32'h7,   1'b0, 1'b0, 1'b0, 32'h0},  // R10 write to read-only
        '{1'b1, 1'b0, 8'h10, 32'h0,   1'b0, 1'b0, 1'b0, 32'h3},  // R10 unchanged
        '{1'b1, 1'b0, 8'h14, 32'h0,   1'b0, 1'b0, 1'b0, 32'h0}   // R10 unused offset
    };

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic ev, input logic tk);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        assert_ev = ev;
        tick_en   = tk;
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        assert_ev = 1'b0;
        tick_en   = 1'b0;
    endtask

    task automatic cyc_chk(input logic wr, input logic [7:0] a, input logic [31:0] d,
                           input logic ev, input logic tk, input logic exp_irq,
                           input string tag);
        cyc(wr, a, d, ev, tk);
        chk(32'(irq_send), 32'(exp_irq), tag);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                rd_chk(VECS[i].addr, VECS[i].exp_rd, $sformatf("table row %0d read", i));
            end else begin
                cyc_chk(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].ev,
                        VECS[i].tk, VECS[i].exp_irq, $sformatf("table row %0d irq", i));
            end
        end

        // R6: drop a pending event by retiring credits to zero
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, "R6 event held by counter");
        cyc_chk(1'b1, 8'h08, 32'h2, 1'b0, 1'b0, 1'b0, "R6 retire to zero");
        rd_chk(8'h08, 32'h0, "R6 credits zero");
        for (int k = 0; k < 3; k++) begin
            cyc_chk(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b0, "R6 counting down");
        end
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, "R6 dropped event not sent");
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R6 fresh event sent");

        // R2: coalescing disabled
        cyc(1'b1, 8'h00, 32'h0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        end
        for (int k = 0; k < 3; k++) begin
            cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R2 back-to-back send");
        end
        rd_chk(8'h10, 32'h0, "R2 counter stays 0");
        rd_chk(8'h08, 32'h4, "R2 credits");

        // R8: auto-mask
        cyc(1'b1, 8'h0C, 32'h1, 1'b0, 1'b0);
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R8 send");
        rd_chk(8'h04, 32'h1, "R8 mask set by send");
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, "R8 masked event held");

        // R7: unmask via credit word
        cyc_chk(1'b1, 8'h08, 32'h0001_0000, 1'b0, 1'b0, 1'b0, "R7 unmask write");
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1, "R7 held event sent after unmask");
        rd_chk(8'h08, 32'h6, "R7 flag bits not stored in credits");

        // R7: reload via credit word
        cyc(1'b1, 8'h0C, 32'h0, 1'b0, 1'b0);
        cyc(1'b1, 8'h00, 32'h5, 1'b0, 1'b0);
        cyc(1'b1, 8'h08, 32'h0001_0000, 1'b0, 1'b0);
        cyc_chk(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R7 send after unmask");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        rd_chk(8'h10, 32'h3, "R7 counter before reload");
        cyc(1'b1, 8'h08, 32'h0002_0000, 1'b0, 1'b0);
        rd_chk(8'h10, 32'h5, "R7 counter reloaded");

        // R12: send and credit write in one cycle
        cyc(1'b1, 8'h00, 32'h0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
        end
        cyc_chk(1'b1, 8'h08, 32'h3, 1'b1, 1'b0, 1'b1, "R12 send with credit write");
        rd_chk(8'h08, 32'h5, "R12 net credits");
        cyc(1'b1, 8'h08, 32'h8, 1'b0, 1'b0);
        rd_chk(8'h08, 32'h0000_FFFD, "R5 signed wrap negative");

        // reset state after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rd_chk(8'h04, 32'h1, "R3 mask after reset");
        rd_chk(8'h08, 32'h0, "R5 credits after reset");
        rd_chk(8'h0C, 32'h0, "R8 auto-mask after reset");
        chk(32'(irq_send), 32'h0, "R1 no send in reset");

        finish_run();
    end

endmodule